// File: doc/BRIEF.md
# Trace Start/Stop Qualifier

This block turns a set of watchpoint match pulses into a single trace-enable qualifier. Each watchpoint input can be chosen, through one 32-bit selection word, to act as a start source, a stop source, or both. A selected start match turns an internal on/off flag on, and a selected stop match turns it off. The flag can be read and overwritten by software through a status port.

A gating control bit chooses whether the flag qualifies tracing at all. When gating is off, tracing runs freely, but the flag keeps following the matches. A programming bit overrides everything else: while it is high, the trace-enable output is low.

Top module: `trace_startstop`

## Requirements
- R1: After reset the flag (`state_o`) is 0 and `trace_en_o` is 1 when `prog_i`=0 and `gate_en_i`=0.
- R2: A match on watchpoint k (k=0..NUM_WP-1) with selection bit k set makes `state_o` 1 in the cycle after the match.
- R3: A match on watchpoint k with selection bit 16+k set makes `state_o` 0 in the cycle after the match.
- R4: A match on a watchpoint whose start and stop selection bits are both 0 leaves `state_o` unchanged.
- R5: If a selected start and a selected stop match in the same cycle, stop wins and `state_o` becomes 0.
- R6: A status write (`st_wr_i`=1) loads `st_wdata_i` into `state_o` on the next cycle and overrides any match in the same cycle.
- R7: With `gate_en_i`=0, `trace_en_o` equals `!prog_i` whatever the flag is. The flag still follows matches.
- R8: With `gate_en_i`=1, `trace_en_o` equals `!prog_i && state_o`, with no added delay.
- R9: While `prog_i`=1, `trace_en_o` is 0.
- R10: Selection bits other than [NUM_WP-1:0] and [16+NUM_WP-1:16] have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_match_i | input | NUM_WP | Watchpoint match pulses, bit k is watchpoint k |
| sel_i | input | 32 | Selection word: start sources in low bits, stop sources from bit 16 |
| gate_en_i | input | 1 | 1: the flag gates tracing; 0: the flag is bypassed |
| prog_i | input | 1 | Programming bit; blocks tracing while high |
| st_wr_i | input | 1 | Software write strobe for the flag |
| st_wdata_i | input | 1 | Value to write into the flag |
| state_o | output | 1 | Current start/stop flag |
| trace_en_o | output | 1 | Trace-enable qualifier |

## Verification
Matches and status writes go through one register, so `state_o` shows their effect one clock edge after they are driven. `trace_en_o` is combinational from `prog_i`, `gate_en_i` and the flag. The bench drives inputs on the falling edge. It samples `state_o` on the next falling edge, after exactly one rising edge. It samples `trace_en_o` a short delay after driving the inputs, within the same cycle.

// File: rtl/trace_startstop.sv
module trace_startstop #(
  parameter int NUM_WP   = 4,
  parameter int STOP_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WP-1:0] wp_match_i,
  input  logic [31:0]       sel_i,
  input  logic              gate_en_i,
  input  logic              prog_i,
  input  logic              st_wr_i,
  input  logic              st_wdata_i,
  output logic              state_o,
  output logic              trace_en_o
);

  logic [NUM_WP-1:0] start_sel, stop_sel;
  logic              start_hit, stop_hit, state_d;

  assign start_sel = sel_i[NUM_WP-1:0];
  assign stop_sel  = sel_i[STOP_LSB +: NUM_WP];
  assign start_hit = |(wp_match_i & start_sel);
  assign stop_hit  = |(wp_match_i & stop_sel);

  always_comb begin
    state_d = state_o;
    if (st_wr_i)        state_d = st_wdata_i;
    else if (stop_hit)  state_d = 1'b0;
    else if (start_hit) state_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_o <= 1'b0;
    else         state_o <= state_d;

  assign trace_en_o = !prog_i && (gate_en_i ? state_o : 1'b1);

  a_r3_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_wr_i && stop_hit) |=> !state_o);
  a_r2_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_wr_i && start_hit && !stop_hit) |=> state_o);
  a_r6_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr_i |=> (state_o == $past(st_wdata_i)));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_wr_i && !start_hit && !stop_hit) |=> $stable(state_o));
  a_r9_prog_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |-> !trace_en_o);
  a_r7_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_en_i && !prog_i) |-> trace_en_o);

endmodule

// File: tb/test_trace_startstop.sv
`timescale 1ns/1ps
module test_trace_startstop;
  logic clk = 0, rst_n = 0;
  logic [3:0] wp = 0;
  logic [31:0] sel = 0;
  logic gate = 0, prog = 0, wr = 0, wd = 0;
  logic state, ten;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  trace_startstop i_trace_startstop (
    .clk_i(clk), .rst_ni(rst_n), .wp_match_i(wp), .sel_i(sel),
    .gate_en_i(gate), .prog_i(prog), .st_wr_i(wr), .st_wdata_i(wd),
    .state_o(state), .trace_en_o(ten));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at negedge, return state after the next posedge
  task automatic step(logic [3:0] m, logic w, logic d);
    wp = m; wr = w; wd = d;
    @(negedge clk);
    wp = 0; wr = 0; wd = 0;
  endtask

  task automatic set_state(logic v);
    step(4'h0, 1'b1, v);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 state", state, 1'b0);
    chk("R1 trace_en", ten, 1'b1);
  endtask

  task automatic t_start_stop;
    for (int k = 0; k < 4; k++) begin
      set_state(1'b0);
      sel = 32'h1 << k;
      step(4'h1 << k, 0, 0);
      chk("R2 start", state, 1'b1);
      sel = 32'h1 << (16 + k);
      step(4'h1 << k, 0, 0);
      chk("R3 stop", state, 1'b0);
    end
  endtask

  task automatic t_unselected;
    set_state(1'b1);
    sel = 32'h0000_0001 | (32'h1 << 17);
    step(4'b1100, 0, 0);
    chk("R4 unselected keeps 1", state, 1'b1);
    set_state(1'b0);
    step(4'b1100, 0, 0);
    chk("R4 unselected keeps 0", state, 1'b0);
  endtask

  task automatic t_both;
    set_state(1'b0);
    sel = 32'h0001_0001;
    step(4'b0001, 0, 0);
    chk("R5 same input both", state, 1'b0);
    set_state(1'b1);
    sel = 32'h0002_0001;
    step(4'b0011, 0, 0);
    chk("R5 two inputs", state, 1'b0);
  endtask

  task automatic t_write;
    sel = 32'h0000_000F;
    step(4'hF, 1, 0);
    chk("R6 write 0 beats start", state, 1'b0);
    sel = 32'h000F_0000;
    step(4'hF, 1, 1);
    chk("R6 write 1 beats stop", state, 1'b1);
  endtask

  task automatic t_gate;
    gate = 0; prog = 0;
    set_state(1'b0); #1;
    chk("R7 bypass state0", ten, 1'b1);
    sel = 32'h1; step(4'h1, 0, 0);
    chk("R7 state follows when bypassed", state, 1'b1);
    gate = 1; #1;
    chk("R8 gated on", ten, 1'b1);
    set_state(1'b0); #1;
    chk("R8 gated off", ten, 1'b0);
    gate = 0;
  endtask

  task automatic t_prog;
    prog = 1; gate = 0; #1;
    chk("R9 prog bypass", ten, 1'b0);
    set_state(1'b1); gate = 1; #1;
    chk("R9 prog gated", ten, 1'b0);
    prog = 0; #1;
    chk("R8 after prog", ten, 1'b1);
    gate = 0;
  endtask

  task automatic t_unused_bits;
    set_state(1'b0);
    sel = 32'hFFF0_FFF0;
    step(4'hF, 0, 0);
    chk("R10 upper start bits ignored", state, 1'b0);
    set_state(1'b1);
    step(4'hF, 0, 0);
    chk("R10 upper stop bits ignored", state, 1'b1);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    t_reset();
    @(negedge clk);
    t_start_stop();
    t_unselected();
    t_both();
    t_write();
    t_gate();
    t_prog();
    t_unused_bits();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule